// File: doc/BRIEF.md
# Floating-Point Widening Converter

This unit turns a 32-bit single-precision or 64-bit double-precision floating-point operand into the 80-bit extended-precision form. The extended form has a 15-bit exponent and a 64-bit significand with an explicit integer bit. A 2-bit format code selects the source type. A value that is already 80 bits wide is forwarded untouched. Widening is always exact, so the unit does no rounding.

The result and two exception flags are registered on the clock edge on which `in_valid` is high, and appear one cycle later. The flags mark a denormal source and a signaling-NaN source. A register-stack push consumes the result directly. The unit handles the special cases as follows:

- A denormal narrow source is normalized into the wider exponent range.
- A signaling NaN is quieted and keeps its payload.
- A two-bit mask input decides which raised flags also request a trap.

Top module: `fpx_widen`

## Requirements
- R1: Format code 0 reads a single from `in_operand[31:0]` and ignores bits 79:32. A normal single gives output exponent = source exponent + 16256. The output integer bit (bit 63) is 1, and the 23 fraction bits sit in output bits 62:40 with zeros below them.
- R2: Format code 1 reads a double from `in_operand[63:0]`. A normal double gives output exponent = source exponent + 15360, integer bit 1, and the 52 fraction bits in output bits 62:11.
- R3: A zero single or double gives exponent 0 and an all-zero significand, keeps its sign, and raises no flag.
- R4: An infinite single or double gives exponent 0x7FFF and significand 0x8000000000000000, keeps its sign, and raises no flag.
- R5: A denormal single or double is normalized. Its significand is shifted left until bit 63 is 1, and the exponent becomes 16256 (single) or 15360 (double) minus the number of leading zeros in the source fraction. `out_denorm` is raised.
- R6: A single or double NaN whose top fraction bit is 0 (signaling) raises `out_invalid`. It is emitted with output bit 62 set and its remaining payload kept in place. A NaN whose top fraction bit is 1 (quiet) is converted the same way and raises no flag.
- R7: Format codes 2 and 3 forward all 80 operand bits unchanged and never raise either flag, even for extended denormals or NaNs.
- R8: The output sign (bit 79) always equals the source sign: bit 31 for singles, bit 63 for doubles, bit 79 otherwise.
- R9: The result, `out_denorm` and `out_invalid` appear on the clock edge after the one on which `in_valid` is high, with `out_valid` high. A cycle with `in_valid` low gives `out_valid`, both flags and `out_trap` low in the next cycle.
- R10: `out_trap` is high exactly when `out_valid` is high and either the denormal flag is raised with `flag_mask[0]` = 0, or the invalid flag is raised with `flag_mask[1]` = 0. A mask bit of 1 suppresses the trap, not the flag.
- R11: A synchronous active-low reset clears `out_valid`, `out_value`, both flags and `out_trap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand is present this cycle |
| in_fmt | input | 2 | Source format: 0 single, 1 double, 2 or 3 extended |
| in_operand | input | 80 | Source operand, right-aligned |
| flag_mask | input | 2 | Trap mask: bit 0 denormal, bit 1 invalid (1 = masked) |
| out_valid | output | 1 | Result registers hold a new conversion |
| out_value | output | 80 | Extended-precision result |
| out_denorm | output | 1 | Source was a denormal single or double |
| out_invalid | output | 1 | Source was a signaling single or double NaN |
| out_trap | output | 1 | An unmasked flag is raised |

## Verification
The bench converts the following kinds of single and double operand: ordinary normals, the smallest and largest normals, signed zeros, infinities, denormals at both ends of the range, and quiet and signaling NaNs with nonzero payloads. The normals with distinct exponents and fractions distinguish a wrong bias from misaligned fraction bits. The denormal extremes separate a wrong leading-zero count from a wrong shift. The NaN pairs show that only the signaling kind is flagged, and that quieting does not disturb the payload. Extended and code-3 inputs that look like denormals and signaling NaNs confirm that the wide path raises no flag, and varied mask patterns separate a raised flag from a requested trap.

// File: rtl/fpx_pkg.sv
// Shared constants and types for the floating-point widening converter.
// Assumes the 80-bit target layout: sign[79], exponent[78:64], significand[63:0].
package fpx_pkg;

    localparam int EXT_W      = 80;
    localparam int EXT_EXP_W  = 15;
    localparam int EXT_SIG_W  = 64;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        FMT_SGL = 2'd0,
        FMT_DBL = 2'd1,
        FMT_EXT = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [EXT_SIG_W-1:0] sig;
    } ext_t;

    typedef struct packed {
        ext_t val;
        logic denorm;
        logic invalid;
    } wide_t;

endpackage

// File: rtl/fpx_lzc.sv
// Leading-zero counter for a W-bit vector.
// Assumes an all-zero vector reports W; callers ignore the count in that case.
module fpx_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // Scan upward so the highest set bit makes the final assignment.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fpx_narrow.sv
// Widens one IEEE binary format with EW exponent and FW fraction bits into
// the 80-bit extended form. The unit is purely combinational.
// Assumes EW < 15 and FW < 63, so every value is exact in the target.
module fpx_narrow
    import fpx_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] src,
    output wide_t          res
);

    localparam int BIAS   = (1 << (EW - 1)) - 1;
    localparam int REBIAS = EXT_BIAS - BIAS;
    localparam int NPAD   = EXT_SIG_W - 1 - FW;
    localparam int DPAD   = EXT_SIG_W - FW;
    localparam int CW     = $clog2(FW + 1);

    logic          s_sign;
    logic [EW-1:0] s_exp;
    logic [FW-1:0] s_frac;
    logic [FW-1:0] frac_quiet;
    logic [CW-1:0] lead_zeros;
    logic          exp_zero;
    logic          exp_full;
    logic          frac_zero;

    // Split the source into its fields.
    always_comb begin
        s_sign    = src[EW+FW];
        s_exp     = src[EW+FW-1:FW];
        s_frac    = src[FW-1:0];
        exp_zero  = (s_exp == '0);
        exp_full  = (s_exp == '1);
        frac_zero = (s_frac == '0);
        frac_quiet         = s_frac;
        frac_quiet[FW-1]   = 1'b1;
    end

    fpx_lzc #(.W(FW), .CW(CW)) u_lzc (
        .vec   (s_frac),
        .count (lead_zeros)
    );

    // Classify the operand and build the widened value and its flags.
    always_comb begin
        res            = '0;
        res.val.sign   = s_sign;
        if (exp_zero && frac_zero) begin
            res.val.exp = '0;
            res.val.sig = '0;
        end else if (exp_zero) begin
            res.val.exp = EXT_EXP_W'(REBIAS) - EXT_EXP_W'(lead_zeros);
            res.val.sig = {s_frac, {DPAD{1'b0}}} << lead_zeros;
            res.denorm  = 1'b1;
        end else if (exp_full && frac_zero) begin
            res.val.exp = '1;
            res.val.sig = {1'b1, {(EXT_SIG_W-1){1'b0}}};
        end else if (exp_full) begin
            res.val.exp = '1;
            res.val.sig = {1'b1, frac_quiet, {NPAD{1'b0}}};
            res.invalid = ~s_frac[FW-1];
        end else begin
            res.val.exp = EXT_EXP_W'(s_exp) + EXT_EXP_W'(REBIAS);
            res.val.sig = {1'b1, s_frac, {NPAD{1'b0}}};
        end
    end

endmodule

// File: rtl/fpx_widen.sv
// Top of the widening converter: one narrow path per narrow format, a format
// mux, and one register stage feeding the register-stack push.
// Assumes in_fmt codes 2 and 3 both mean an 80-bit source.
module fpx_widen
    import fpx_pkg::*;
#(
    parameter int SGL_EW = 8,
    parameter int SGL_FW = 23,
    parameter int DBL_EW = 11,
    parameter int DBL_FW = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_fmt,
    input  logic [EXT_W-1:0] in_operand,
    input  logic [1:0]       flag_mask,
    output logic             out_valid,
    output logic [EXT_W-1:0] out_value,
    output logic             out_denorm,
    output logic             out_invalid,
    output logic             out_trap
);

    localparam int NUM_NARROW = 2;

    wide_t narrow_res [NUM_NARROW];
    wide_t picked;
    logic  trap_next;

    // One conversion path per narrow format; index 0 single, 1 double.
    for (genvar g = 0; g < NUM_NARROW; g++) begin : g_narrow
        localparam int EW = (g == 0) ? SGL_EW : DBL_EW;
        localparam int FW = (g == 0) ? SGL_FW : DBL_FW;
        fpx_narrow #(.EW(EW), .FW(FW)) u_path (
            .src (in_operand[EW+FW:0]),
            .res (narrow_res[g])
        );
    end

    // Select the path for the requested format; wide sources pass through.
    always_comb begin
        unique case (fmt_e'(in_fmt))
            FMT_SGL: picked = narrow_res[0];
            FMT_DBL: picked = narrow_res[1];
            default: picked = '{val: ext_t'(in_operand), denorm: 1'b0, invalid: 1'b0};
        endcase
        trap_next = (picked.denorm & ~flag_mask[0]) | (picked.invalid & ~flag_mask[1]);
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_value   <= '0;
            out_denorm  <= 1'b0;
            out_invalid <= 1'b0;
            out_trap    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value   <= picked.val;
                out_denorm  <= picked.denorm;
                out_invalid <= picked.invalid;
                out_trap    <= trap_next;
            end else begin
                out_denorm  <= 1'b0;
                out_invalid <= 1'b0;
                out_trap    <= 1'b0;
            end
        end
    end

    assert_ext_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt[1]) |=> (!out_denorm && !out_invalid));

    assert_ext_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt[1]) |=> (out_value == $past(in_operand)));

    assert_sign_sgl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'd0) |=> (out_value[79] == $past(in_operand[31])));

    assert_sign_dbl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 2'd1) |=> (out_value[79] == $past(in_operand[63])));

    assert_denorm_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_denorm |-> (out_value[63] && out_value[78:64] != '0));

    assert_snan_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_value[78:64] == '1 && out_value[62]));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_denorm && !out_invalid && !out_trap));

    assert_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_valid && (out_denorm || out_invalid)));

endmodule

// File: tb/fpx_widen_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// idle and reset checks.
module fpx_widen_test;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [79:0] opnd;
        logic [1:0]  mask;
        logic [79:0] val;
        logic        d;
        logic        i;
        logic        t;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 80'h3F800000,                 2'b00, 80'h3FFF_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 1.0
        '{2'd0, 80'hABCD12345678_3F800000,    2'b00, 80'h3FFF_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 upper bits ignored
        '{2'd0, 80'hC0200000,                 2'b00, 80'hC000_A000000000000000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 -2.5
        '{2'd0, 80'h7F7FFFFF,                 2'b00, 80'h407E_FFFFFF0000000000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 max normal
        '{2'd0, 80'h00800000,                 2'b00, 80'h3F81_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 min normal
        '{2'd1, 80'h3FF0000000000000,         2'b00, 80'h3FFF_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 1.0
        '{2'd1, 80'hBFE8000000000000,         2'b00, 80'hBFFE_C000000000000000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 -0.75
        '{2'd1, 80'h7FEFFFFFFFFFFFFF,         2'b00, 80'h43FE_FFFFFFFFFFFFF800, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 max normal
        '{2'd0, 80'h00000000,                 2'b00, 80'h0000_0000000000000000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 +0
        '{2'd0, 80'h80000000,                 2'b00, 80'h8000_0000000000000000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 -0
        '{2'd1, 80'h8000000000000000,         2'b00, 80'h8000_0000000000000000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 -0 double
        '{2'd0, 80'h7F800000,                 2'b00, 80'h7FFF_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 +inf
        '{2'd1, 80'hFFF0000000000000,         2'b00, 80'hFFFF_8000000000000000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 -inf
        '{2'd0, 80'h00000001,                 2'b00, 80'h3F6A_8000000000000000, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 min denorm
        '{2'd0, 80'h007FFFFF,                 2'b01, 80'h3F80_FFFFFE0000000000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 max denorm
        '{2'd1, 80'h0000000000000001,         2'b10, 80'h3BCD_8000000000000000, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 min denorm
        '{2'd1, 80'h8008000000000000,         2'b00, 80'hBC00_8000000000000000, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 neg denorm
        '{2'd0, 80'h7F800001,                 2'b00, 80'h7FFF_C000010000000000, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 SNaN
        '{2'd0, 80'hFFC00000,                 2'b00, 80'hFFFF_C000000000000000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 QNaN
        '{2'd1, 80'h7FF0000000000123,         2'b10, 80'h7FFF_C000000000091800, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 SNaN payload
        '{2'd1, 80'h7FF8000000000000,         2'b00, 80'h7FFF_C000000000000000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 QNaN
        '{2'd2, 80'h0000_0000000000000001,    2'b00, 80'h0000_0000000000000001, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ext denorm
        '{2'd2, 80'h7FFF_8000000000000001,    2'b00, 80'h7FFF_8000000000000001, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ext SNaN
        '{2'd3, 80'h4000_C000000000000000,    2'b00, 80'h4000_C000000000000000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 code 3
        '{2'd0, 80'h7F800001,                 2'b11, 80'h7FFF_C000010000000000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 masked
        '{2'd1, 80'h0000000000000001,         2'b01, 80'h3BCD_8000000000000000, 1'b1, 1'b0, 1'b0, 4'd10}  // R10 masked
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_fmt;
    logic [79:0] in_operand;
    logic [1:0]  flag_mask;
    logic        out_valid;
    logic [79:0] out_value;
    logic        out_denorm;
    logic        out_invalid;
    logic        out_trap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    fpx_widen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_fmt      (in_fmt),
        .in_operand  (in_operand),
        .flag_mask   (flag_mask),
        .out_valid   (out_valid),
        .out_value   (out_value),
        .out_denorm  (out_denorm),
        .out_invalid (out_invalid),
        .out_trap    (out_trap)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_fmt     = 2'd0;
        in_operand = '0;
        flag_mask  = 2'b00;
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state
        chk(out_valid == 1'b0 && out_value == '0 && !out_denorm && !out_invalid && !out_trap,
            "R11 reset state", {75'd0, out_valid, out_denorm, out_invalid, out_trap, 1'b0}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at negedge, result registered at the next posedge.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_fmt     = VECS[k].fmt;
            in_operand = VECS[k].opnd;
            flag_mask  = VECS[k].mask;
            @(posedge clk);
            #2;
            chk(out_valid == 1'b1, $sformatf("R9 valid vec %0d", k), {79'd0, out_valid}, 80'd1);
            chk(out_value == VECS[k].val, $sformatf("R%0d value vec %0d", VECS[k].req, k), out_value, VECS[k].val);
            chk(out_denorm == VECS[k].d && out_invalid == VECS[k].i,
                $sformatf("R%0d flags vec %0d", VECS[k].req, k),
                {78'd0, out_denorm, out_invalid}, {78'd0, VECS[k].d, VECS[k].i});
            chk(out_trap == VECS[k].t, $sformatf("R10 trap vec %0d", k), {79'd0, out_trap}, {79'd0, VECS[k].t});
        end

        // R9: idle cycle after a flagged conversion drops valid, flags, trap.
        @(negedge clk);
        in_valid   = 1'b1;
        in_fmt     = 2'd0;
        in_operand = 80'h7F800001;
        flag_mask  = 2'b00;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        chk(!out_valid && !out_denorm && !out_invalid && !out_trap, "R9 idle clears",
            {76'd0, out_valid, out_denorm, out_invalid, out_trap}, '0);

        // R11: reset during operation clears everything.
        @(negedge clk);
        in_valid   = 1'b1;
        in_fmt     = 2'd1;
        in_operand = 80'h0000000000000001;
        @(posedge clk);
        #2;
        chk(out_denorm && out_trap, "R5 pre-reset flag", {78'd0, out_denorm, out_trap}, 80'd3);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk(!out_valid && out_value == '0 && !out_denorm && !out_invalid && !out_trap,
            "R11 mid-run reset", out_value, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule